// File: doc/BRIEF.md
# DTMF Tone-Pair Period Decoder

This block turns two limited square waves into a validated key code. One input carries the tone from the low frequency band and the other carries the tone from the high band. Each wave is sampled through a two-flop synchronizer. The block then counts reference-clock cycles between rising edges and adds up a fixed number of consecutive periods. It compares that sum with an acceptance window around each of the four nominal frequencies of the band. Averaging over several periods lets the block accept a slightly detuned tone while rejecting a signal that only briefly looks like a valid tone.

Early steering is high while both bands hold a valid match. A digital guard timer takes the place of an external RC network. Once early steering has stayed high for a programmable number of cycles, the block does three things: it latches the 4-bit key code, pulses a one-cycle strobe and raises the guard output. The guard output holds through short dropouts. It falls only after early steering has stayed low for a programmable release time.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: Low-band classification. After synchronization, the period between successive rising edges of `lo_tone_i` is counted in clock cycles. `AVG_PERIODS` periods are summed. The sum matches a row when it lies within ±1.5 % of `AVG_PERIODS*CLK_HZ/f`. The row frequencies are 697, 770, 852 and 941 Hz, numbered row 0 to row 3. A tone detuned by 0.8 % still matches.
- R2: High-band classification. `hi_tone_i` is measured the same way as in R1. The column frequencies are 1209, 1336, 1477 and 1633 Hz, numbered column 0 to column 3.
- R3: A band whose period sum falls outside all four of its windows is invalid. With one band invalid, `early_steer_o` never rises and nothing is registered.
- R4: `early_steer_o` is high only while both bands are valid. A band becomes invalid when its input shows no rising edge for twice the period of its lowest nominal frequency. A single tone on only one band gives no early steering.
- R5: A pair is registered only after `early_steer_o` has stayed high for `VALID_CYC` consecutive cycles. A shorter condition registers nothing.
- R6: The key code is a function of row and column. Row 0 gives 1, 2, 3, 13. Row 1 gives 4, 5, 6, 14. Row 2 gives 7, 8, 9, 15. Row 3 gives 11, 10, 12, 0.
- R7: `key_valid_o` pulses for exactly one cycle at each registration. `key_code_o` keeps its value until the next registration.
- R8: `guard_o` rises together with the registration strobe and stays high while early steering is high. It falls only after early steering has been low for `RELEASE_CYC` consecutive cycles. While `guard_o` is high, no new registration occurs, so a short gap within one key press gives a single code.
- R9: During and right after reset, `early_steer_o`, `guard_o` and `key_valid_o` are 0 and `key_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `CLK_HZ` cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_tone_i | input | 1 | Limited low-band tone, asynchronous |
| hi_tone_i | input | 1 | Limited high-band tone, asynchronous |
| early_steer_o | output | 1 | Both bands hold a valid match |
| guard_o | output | 1 | Registered pair present, held through short dropouts |
| key_code_o | output | 4 | Last registered key code |
| key_valid_o | output | 1 | One-cycle strobe on each new code |

## Verification
The assertions assume that the tone inputs are clean square waves whose rising edges are at least a few clock cycles apart. They also assume that each band holds one steady frequency for the length of a measurement. The properties on the guard timer and the code register depend only on the sequence of early steering and not on the tone values. The stimulus generates each tone from a real-valued phase accumulator, so the period sum stays within one cycle of the ideal. Between key presses it leaves gaps longer than the loss-of-tone time plus the release time. The only exception is the dropout case, which uses a short gap on purpose.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int BANDS = 4;

  // Nominal tone frequency in Hz for band grp (0 = low, 1 = high), slot idx.
  function automatic int nom_hz(input int grp, input int idx);
    int f;
    if (grp == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Row/column to 4-bit key code.
  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    case ({row, col})
      4'h0: c = 4'd1;   4'h1: c = 4'd2;   4'h2: c = 4'd3;   4'h3: c = 4'd13;
      4'h4: c = 4'd4;   4'h5: c = 4'd5;   4'h6: c = 4'd6;   4'h7: c = 4'd14;
      4'h8: c = 4'd7;   4'h9: c = 4'd8;   4'hA: c = 4'd9;   4'hB: c = 4'd15;
      4'hC: c = 4'd11;  4'hD: c = 4'd10;  4'hE: c = 4'd12;  default: c = 4'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int CLK_HZ      = 1_000_000,
  parameter int GRP         = 0,
  parameter int AVG_PERIODS = 4,
  parameter int TOL_PPT     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_i,
  output logic       valid_o,
  output logic [1:0] idx_o
);
  localparam int F_MIN   = dtmf_pkg::nom_hz(GRP, 0);
  localparam int MAX_PER = 2 * (CLK_HZ / F_MIN) + 2;
  localparam int CNT_W   = $clog2(MAX_PER + 1);
  localparam int ACC_W   = $clog2(AVG_PERIODS * MAX_PER + 1);
  localparam int PER_W   = $clog2(AVG_PERIODS + 1);

  logic tone_s;
  dtmf_sync u_sync (.clk(clk), .rst_n(rst_n), .d_i(tone_i), .q_o(tone_s));

  logic             tone_q, tone_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             armed_q, armed_d;
  logic             valid_q, valid_d;
  logic [1:0]       idx_q, idx_d;

  logic             rise, timeout, frame_end, hit;
  logic [ACC_W-1:0] sum_now;
  logic [3:0]       match;
  logic [1:0]       hit_idx;

  assign rise      = tone_s & ~tone_q;
  assign timeout   = armed_q && (cnt_q == CNT_W'(MAX_PER));
  assign sum_now   = acc_q + ACC_W'(cnt_q);
  assign frame_end = rise && armed_q && (per_q == PER_W'(AVG_PERIODS - 1));

  for (genvar k = 0; k < dtmf_pkg::BANDS; k++) begin : g_win
    localparam int SUM_NOM = (AVG_PERIODS * CLK_HZ) / dtmf_pkg::nom_hz(GRP, k);
    localparam int SUM_TOL = (SUM_NOM * TOL_PPT) / 1000;
    assign match[k] = (sum_now >= ACC_W'(SUM_NOM - SUM_TOL)) &&
                      (sum_now <= ACC_W'(SUM_NOM + SUM_TOL));
  end

  assign hit = |match;

  always_comb begin
    hit_idx = 2'd0;
    for (int k = dtmf_pkg::BANDS - 1; k >= 0; k--) begin
      if (match[k]) hit_idx = 2'(k);
    end
  end

  always_comb begin
    tone_d  = tone_s;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    per_d   = per_q;
    armed_d = armed_q;
    valid_d = valid_q;
    idx_d   = idx_q;
    if (rise) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
      if (!armed_q || frame_end) begin
        acc_d = '0;
        per_d = '0;
      end else begin
        acc_d = sum_now;
        per_d = per_q + PER_W'(1);
      end
      if (frame_end) begin
        valid_d = hit;
        if (hit) idx_d = hit_idx;
      end
    end else if (timeout) begin
      armed_d = 1'b0;
      valid_d = 1'b0;
      acc_d   = '0;
      per_d   = '0;
    end else if (cnt_q != CNT_W'(MAX_PER)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q  <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      per_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= 2'd0;
    end else begin
      tone_q  <= tone_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  AST_VALID_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(valid_q) |-> $past(frame_end || timeout)); // R1
  AST_SILENCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !valid_q); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_PER)); // R4
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int VALID_CYC   = 40_000,
  parameter int RELEASE_CYC = 30_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       est_i,
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  output logic       guard_o,
  output logic [3:0] code_o,
  output logic       strobe_o
);
  localparam int V_W = $clog2(VALID_CYC + 1);
  localparam int R_W = $clog2(RELEASE_CYC + 1);

  logic [V_W-1:0] vcnt_q, vcnt_d;
  logic [R_W-1:0] rcnt_q, rcnt_d;
  logic           gt_q, gt_d;
  logic           dv_q, dv_d;
  logic [3:0]     code_q, code_d;

  always_comb begin
    vcnt_d = vcnt_q;
    rcnt_d = rcnt_q;
    gt_d   = gt_q;
    code_d = code_q;
    dv_d   = 1'b0;
    if (!gt_q) begin
      rcnt_d = '0;
      if (!est_i) begin
        vcnt_d = '0;
      end else if (vcnt_q == V_W'(VALID_CYC - 1)) begin
        vcnt_d = '0;
        gt_d   = 1'b1;
        dv_d   = 1'b1;
        code_d = dtmf_pkg::key_code(row_i, col_i);
      end else begin
        vcnt_d = vcnt_q + V_W'(1);
      end
    end else begin
      vcnt_d = '0;
      if (est_i) begin
        rcnt_d = '0;
      end else if (rcnt_q == R_W'(RELEASE_CYC - 1)) begin
        rcnt_d = '0;
        gt_d   = 1'b0;
      end else begin
        rcnt_d = rcnt_q + R_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      rcnt_q <= '0;
      gt_q   <= 1'b0;
      dv_q   <= 1'b0;
      code_q <= 4'd0;
    end else begin
      vcnt_q <= vcnt_d;
      rcnt_q <= rcnt_d;
      gt_q   <= gt_d;
      dv_q   <= dv_d;
      code_q <= code_d;
    end
  end

  assign guard_o  = gt_q;
  assign code_o   = code_q;
  assign strobe_o = dv_q;

  // Independent run-length counters of the early-steering level.
  logic [V_W-1:0] hi_run_q;
  logic [R_W-1:0] lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      hi_run_q <= !est_i ? '0 : (hi_run_q == V_W'(VALID_CYC)) ? hi_run_q : hi_run_q + V_W'(1);
      lo_run_q <= est_i ? '0 : (lo_run_q == R_W'(RELEASE_CYC)) ? lo_run_q : lo_run_q + R_W'(1);
    end
  end

  AST_VALIDATION_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gt_q) |-> ($past(est_i) && $past(hi_run_q) >= V_W'(VALID_CYC - 1))); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |=> !dv_q); // R7
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dv_q |-> $stable(code_q)); // R7
  AST_STROBE_WITH_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> (gt_q && !$past(gt_q))); // R8
  AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_q && est_i) |=> gt_q); // R8
  AST_RELEASE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gt_q) |-> ($past(lo_run_q) >= R_W'(RELEASE_CYC - 1))); // R8
endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder #(
  parameter int CLK_HZ      = 1_000_000,
  parameter int AVG_PERIODS = 4,
  parameter int TOL_PPT     = 15,
  parameter int VALID_CYC   = 40_000,
  parameter int RELEASE_CYC = 30_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_tone_i,
  input  logic       hi_tone_i,
  output logic       early_steer_o,
  output logic       guard_o,
  output logic [3:0] key_code_o,
  output logic       key_valid_o
);
  logic       lo_valid, hi_valid, est;
  logic [1:0] row, col;

  dtmf_period_meter #(.CLK_HZ(CLK_HZ), .GRP(0), .AVG_PERIODS(AVG_PERIODS), .TOL_PPT(TOL_PPT))
    u_lo_meter (.clk(clk), .rst_n(rst_n), .tone_i(lo_tone_i), .valid_o(lo_valid), .idx_o(row));

  dtmf_period_meter #(.CLK_HZ(CLK_HZ), .GRP(1), .AVG_PERIODS(AVG_PERIODS), .TOL_PPT(TOL_PPT))
    u_hi_meter (.clk(clk), .rst_n(rst_n), .tone_i(hi_tone_i), .valid_o(hi_valid), .idx_o(col));

  assign est = lo_valid & hi_valid;

  dtmf_guard_timer #(.VALID_CYC(VALID_CYC), .RELEASE_CYC(RELEASE_CYC))
    u_guard (.clk(clk), .rst_n(rst_n), .est_i(est), .row_i(row), .col_i(col),
             .guard_o(guard_o), .code_o(key_code_o), .strobe_o(key_valid_o));

  assign early_steer_o = est;

  AST_GUARD_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_o) |-> $past(lo_valid && hi_valid)); // R4
endmodule

// File: tb/dtmf_pair_decoder_tb.sv
`timescale 1ns/1ps
module dtmf_pair_decoder_tb;
  localparam int  CLK_HZ  = 100_000;
  localparam int  VALID   = 600;
  localparam int  RELEASE = 2000;
  localparam real LOF [4] = '{697.0, 770.0, 852.0, 941.0};
  localparam real HIF [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
  localparam int  KEY [4][4] = '{'{1, 2, 3, 13}, '{4, 5, 6, 14}, '{7, 8, 9, 15}, '{11, 10, 12, 0}};

  logic clk = 1'b0;
  logic rst_n;
  logic lo_sq, hi_sq;
  logic est, gt, dv;
  logic [3:0] code;

  always #2.5 clk = ~clk;

  dtmf_pair_decoder #(.CLK_HZ(CLK_HZ), .AVG_PERIODS(4), .TOL_PPT(15),
                      .VALID_CYC(VALID), .RELEASE_CYC(RELEASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .lo_tone_i(lo_sq), .hi_tone_i(hi_sq),
    .early_steer_o(est), .guard_o(gt), .key_code_o(code), .key_valid_o(dv));

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int last_exp = 0;
  bit gt_seen, est_seen, gt_fell, dv_prev, gt_prev;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Tone generator: real-valued phase, toggles on falling clock edges.
  int  cyc = 0;
  real lo_half = 0.0, hi_half = 0.0, lo_next = 0.0, hi_next = 0.0;
  initial begin
    lo_sq = 1'b0;
    hi_sq = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (lo_half > 0.0) begin
        if (real'(cyc) >= lo_next) begin lo_sq = ~lo_sq; lo_next += lo_half; end
      end else lo_sq = 1'b0;
      if (hi_half > 0.0) begin
        if (real'(cyc) >= hi_next) begin hi_sq = ~hi_sq; hi_next += hi_half; end
      end else hi_sq = 1'b0;
    end
  end

  task automatic set_tone(input real fl, input real fh);
    @(posedge clk);
    lo_half = (fl > 0.0) ? real'(CLK_HZ) / (2.0 * fl) : 0.0;
    hi_half = (fh > 0.0) ? real'(CLK_HZ) / (2.0 * fh) : 0.0;
    lo_next = real'(cyc) + lo_half;
    hi_next = real'(cyc) + hi_half;
  endtask

  // Driver: optionally queues the expected code, plays a tone pair, then silence.
  task automatic press(input real fl, input real fh, input int dur, input int gap,
                       input bit expect_code, input int code_exp);
    if (expect_code) begin exp_q.push_back(code_exp); last_exp = code_exp; end
    gt_seen = 0; est_seen = 0; gt_fell = 0;
    set_tone(fl, fh);
    repeat (dur) @(posedge clk);
    set_tone(0.0, 0.0);
    repeat (gap) @(posedge clk);
  endtask

  // Monitor: pops expected codes on each strobe.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dv) begin
        chk(!dv_prev, "R7 strobe width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R5/R8 unexpected code", int'(code), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(code) == e, "R6 key code", int'(code), e);
        end
        chk(gt == 1'b1, "R8 guard with strobe", int'(gt), 1);
      end
      if (gt) gt_seen = 1;
      if (est) est_seen = 1;
      if (gt_prev && !gt) gt_fell = 1;
      dv_prev = dv;
      gt_prev = gt;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk({est, gt, dv, code} == 7'd0, "R9 reset outputs", int'({est, gt, dv, code}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk({est, gt, dv, code} == 7'd0, "R9 after release", int'({est, gt, dv, code}), 0);

    // R1 R2 R6: every row/column pair.
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        press(LOF[r], HIF[c], 1800, 3000, 1'b1, KEY[r][c]);
        chk(exp_q.size() == 0, "R1 R2 pair registered", exp_q.size(), 0);
        chk(gt_seen, "R8 guard raised", int'(gt_seen), 1);
        chk(!gt && !est, "R8 guard released after silence", int'({gt, est}), 0);
      end
    end

    // R1: 0.8 % detuned tones still decode.
    press(LOF[2] * 1.008, HIF[1] * 0.992, 1800, 3000, 1'b1, KEY[2][1]);
    chk(exp_q.size() == 0, "R1 detuned accepted", exp_q.size(), 0);

    // R3: low tone 5 % off and high tone between columns.
    press(LOF[0] * 1.05, HIF[0], 1800, 3000, 1'b0, 0);
    chk(!est_seen && !gt_seen, "R3 off-frequency low", int'({est_seen, gt_seen}), 0);
    press(LOF[1], HIF[1] * 0.95, 1800, 3000, 1'b0, 0);
    chk(!est_seen && !gt_seen, "R3 off-frequency high", int'({est_seen, gt_seen}), 0);

    // R4: only one band present.
    press(LOF[3], 0.0, 1800, 3000, 1'b0, 0);
    chk(!est_seen, "R4 single band", int'(est_seen), 0);

    // R5: condition shorter than the validation time.
    press(LOF[0], HIF[0], 720, 3000, 1'b0, 0);
    chk(est_seen, "R5 short condition appeared", int'(est_seen), 1);
    chk(!gt_seen, "R5 short condition not registered", int'(gt_seen), 0);

    // R8: dropout inside one key press gives one code.
    press(LOF[1], HIF[1], 1800, 300, 1'b1, KEY[1][1]);
    gt_fell = 0;
    set_tone(LOF[1], HIF[1]);
    repeat (1800) @(posedge clk);
    chk(!gt_fell, "R8 guard held over dropout", int'(gt_fell), 0);
    chk(exp_q.size() == 0, "R8 single registration", exp_q.size(), 0);
    set_tone(0.0, 0.0);
    repeat (3000) @(posedge clk);
    chk(!gt, "R8 guard released", int'(gt), 0);

    // R7: code held after registration.
    #1;
    chk(int'(code) == last_exp, "R7 code held", int'(code), last_exp);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule